// File: doc/BRIEF.md
# Bi-Endian Byte-Addressable Memory

This block is a small synchronous memory. Each address holds one byte, and a single port reads or writes a byte, a halfword or a 32-bit word. A multi-byte access covers consecutive addresses, starting at the access address. A runtime select chooses the byte ordering, so software may store a value in one ordering and fetch it in either. Stores take their bytes from the data input. Loads return the value zero-extended in the low bits of the read data word, one clock after the request.

The access must be aligned to its size. When it is not, the access is dropped and an error flag is raised for one cycle. While the enable is low, the memory contents and the read data register both keep their values.

Top module: `biendian_mem`

## Requirements
- R1: After reset every byte of the memory reads as zero, and both `rdata` and `align_err` are zero.
- R2: With `big_end`=0, a word access (`size`=2 or 3) places bits [7:0] of the value at the access address and bits [31:24] at address+3.
- R3: With `big_end`=1, a word access places bits [31:24] of the value at the access address and bits [7:0] at address+3. Writing 0x87654321 to address 0 gives bytes 0x87, 0x65, 0x43, 0x21 at addresses 0 to 3.
- R4: A halfword access (`size`=1) covers two addresses and follows the same ordering: bits [7:0] go at the lower address when `big_end`=0, and bits [15:8] go there when `big_end`=1.
- R5: A byte access (`size`=0) reads or writes bits [7:0] at the access address and does not depend on `big_end`.
- R6: Byte loads return zero in bits [31:8] of `rdata`, and halfword loads return zero in bits [31:16].
- R7: A load presented at one rising edge shows its data on `rdata` after that edge. `rdata` changes at no other time except reset.
- R8: While `en` is low, no byte is written, `rdata` holds, and `align_err` is zero after the edge.
- R9: An enabled write leaves `rdata` unchanged.
- R10: An enabled access whose address is not a multiple of its size sets `align_err` after that edge and leaves both the memory and `rdata` unchanged. `align_err` is zero after any other cycle.
- R11: A word stored in one ordering and loaded in the other comes back with its four bytes reversed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Access enable |
| wr | input | 1 | 1 = store, 0 = load |
| big_end | input | 1 | 1 = most significant byte at lowest address |
| size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Store value, right-justified |
| rdata | output | 32 | Load result, zero-extended |
| align_err | output | 1 | Previous enabled access was misaligned |

## Verification
The assertions assume that `en`, `wr`, `size` and `addr` are steady and known at each rising edge, and that reset is held for at least one edge before the first access. The bench changes inputs only on falling edges and draws every field from the full legal range, `size`=3 included. This covers misaligned addresses, idle cycles and both orderings without leaving that contract. The bench also keeps a byte array of its own, which is what lets loads of bytes written in the other ordering be checked.

// File: rtl/biendian_mem.sv
module biendian_mem #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr,
  input  logic              big_end,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              align_err
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]  mem [DEPTH];
  logic [2:0]  nbytes;
  logic        misalign;
  logic [31:0] rd_val;

  assign nbytes   = (size == 2'd0) ? 3'd1 : (size == 2'd1) ? 3'd2 : 3'd4;
  assign misalign = ((size == 2'd1) && addr[0]) || (size[1] && (addr[1:0] != 2'b00));

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < 4; i++) begin
      if (3'(i) < nbytes)
        rd_val[8*(big_end ? (int'(nbytes) - 1 - i) : i) +: 8] = mem[addr + ADDR_W'(i)];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= '0;
      rdata     <= '0;
      align_err <= 1'b0;
    end else begin
      align_err <= en && misalign;
      if (en && !misalign) begin
        if (wr) begin
          for (int i = 0; i < 4; i++) begin
            if (3'(i) < nbytes)
              mem[addr + ADDR_W'(i)] <= wdata[8*(big_end ? (int'(nbytes) - 1 - i) : i) +: 8];
          end
        end else begin
          rdata <= rd_val;
        end
      end
    end
  end

  assert_err_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    en && misalign |=> align_err);
  assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    en && misalign |=> $stable(rdata));
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(rdata) && !align_err);
  assert_write_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    en && wr |=> $stable(rdata));
  assert_zext_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en && !wr && size == 2'd0 |=> rdata[31:8] == 24'd0);
  assert_zext_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en && !wr && size == 2'd1 && !addr[0] |=> rdata[31:16] == 16'd0);
endmodule

// File: tb/test_biendian_mem.sv
`timescale 1ns/1ps
module test_biendian_mem;
  localparam int AW = 6;
  localparam int N  = 1 << AW;

  logic clk = 0, rst_n = 0, en = 0, wr = 0, big_end = 0;
  logic [1:0] size = 0;
  logic [AW-1:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic align_err;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] ref_mem [N];
  logic [31:0] exp_rd = 0;

  always #10 clk = ~clk;

  biendian_mem #(.ADDR_W(AW)) i_biendian_mem (
    .clk(clk), .rst_n(rst_n), .en(en), .wr(wr), .big_end(big_end), .size(size),
    .addr(addr), .wdata(wdata), .rdata(rdata), .align_err(align_err));

  function automatic int width_of(logic [1:0] s);
    return (s == 0) ? 1 : (s == 1) ? 2 : 4;
  endfunction

  function automatic bit is_bad(logic [1:0] s, logic [AW-1:0] a);
    return (a % width_of(s)) != 0;
  endfunction

  function automatic logic [31:0] model_load(logic [1:0] s, logic b, logic [AW-1:0] a);
    logic [31:0] v = 0;
    int n = width_of(s);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] p = a + AW'(i);
      if (b) v = (v << 8) | 32'(ref_mem[p]);
      else   v = v | (32'(ref_mem[p]) << (8*i));
    end
    return v;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic access(logic e, logic w, logic b, logic [1:0] s, logic [AW-1:0] a,
                        logic [31:0] d, string req);
    bit bad;
    @(negedge clk);
    en = e; wr = w; big_end = b; size = s; addr = a; wdata = d;
    bad = is_bad(s, a);
    @(posedge clk);
    #1;
    if (e && !bad) begin
      if (w) begin
        int n = width_of(s);
        for (int i = 0; i < n; i++) begin
          logic [AW-1:0] p = a + AW'(i);
          ref_mem[p] = b ? d[8*(n-1-i) +: 8] : d[8*i +: 8];
        end
      end else exp_rd = model_load(s, b, a);
    end
    chk(rdata == exp_rd, req, rdata, exp_rd);
    chk(align_err == (e && bad), {req, " err"}, 32'(align_err), 32'(e && bad));
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 7;
    void'($urandom(seed));
    for (int j = 0; j < N; j++) ref_mem[j] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk(rdata == 0, "R1 rdata", rdata, 0);
    chk(align_err == 0, "R1 err", 32'(align_err), 0);
    for (int j = 0; j < N; j += 4) access(1, 0, 0, 2, AW'(j), 0, "R1 zero word");

    // R3 / R2 documented layout
    access(1, 1, 1, 2, 0, 32'h87654321, "R3 write");
    access(1, 1, 0, 2, 4, 32'h87654321, "R2 write");
    access(1, 0, 0, 0, 0, 0, "R3 byte0");
    chk(rdata == 32'h87, "R3 byte0 value", rdata, 32'h87);
    access(1, 0, 1, 0, 3, 0, "R3 byte3");
    chk(rdata == 32'h21, "R3 byte3 value", rdata, 32'h21);
    access(1, 0, 1, 0, 4, 0, "R2 byte4");
    chk(rdata == 32'h21, "R2 byte4 value", rdata, 32'h21);
    access(1, 0, 0, 0, 7, 0, "R2 byte7");
    chk(rdata == 32'h87, "R2 byte7 value", rdata, 32'h87);
    // R11 cross-mode
    access(1, 0, 0, 2, 0, 0, "R11 cross");
    chk(rdata == 32'h21436587, "R11 cross value", rdata, 32'h21436587);
    // R4 halfword, R6 zero extension
    access(1, 1, 1, 1, 8, 32'hFFFFA1B2, "R4 half write");
    access(1, 0, 0, 0, 8, 0, "R4 half byte");
    chk(rdata == 32'hA1, "R4 half msb low addr", rdata, 32'hA1);
    access(1, 0, 0, 1, 8, 0, "R6 half load");
    chk(rdata == 32'h0000B2A1, "R6 half zext", rdata, 32'h0000B2A1);
    // R5 byte ignores mode
    access(1, 1, 1, 0, 13, 32'hFFFFFF5C, "R5 byte write");
    access(1, 0, 0, 0, 13, 0, "R5 byte read");
    chk(rdata == 32'h5C, "R5 byte value", rdata, 32'h5C);
    // R7 latency, R9 hold on write
    access(1, 1, 0, 2, 12, 32'hCAFE0123, "R9 write hold");
    chk(rdata == 32'h5C, "R9 rdata unchanged", rdata, 32'h5C);
    access(1, 0, 0, 2, 12, 0, "R7 load");
    chk(rdata == 32'hCAFE0123, "R7 one cycle", rdata, 32'hCAFE0123);
    // R8 disabled write
    access(0, 1, 0, 2, 12, 32'h11111111, "R8 idle write");
    access(1, 0, 0, 2, 12, 0, "R8 readback");
    chk(rdata == 32'hCAFE0123, "R8 no write", rdata, 32'hCAFE0123);
    // R10 misaligned suppressed
    access(1, 1, 0, 2, 13, 32'h22222222, "R10 bad write");
    access(1, 0, 0, 1, 15, 0, "R10 bad read");
    access(1, 0, 0, 2, 12, 0, "R10 readback");
    chk(rdata == 32'hCAFE0123, "R10 suppressed", rdata, 32'hCAFE0123);

    for (int k = 0; k < 3000; k++) begin
      logic e = ($urandom % 8) != 0;
      logic w = $urandom % 2;
      logic b = $urandom % 2;
      logic [1:0] s = 2'($urandom % 4);
      logic [AW-1:0] a = AW'($urandom);
      string req;
      if ($urandom % 4 != 0) a = a & ~AW'(width_of(s) - 1);
      if (!e) req = "R8";
      else if (is_bad(s, a)) req = "R10";
      else if (w) req = "R9";
      else if (s == 0) req = "R5";
      else if (s == 1) req = "R4";
      else if (b) req = "R3";
      else req = "R2";
      access(e, w, b, s, a, $urandom, req);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule